// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an auto-zeroing, auto-polarity dual-slope analog-to-digital converter. It walks a six-phase conversion cycle and drives the analog switch controls around an external integrator: it shorts the integrator and charges the offset-holding capacitor, runs an offset-measurement ramp, connects the unknown input for a fixed up-ramp, and then connects the reference for the down-ramp. A single comparator input is the only feedback.

Zero correction is digital. During the offset-measurement phase the block counts clocks until the comparator trips and keeps that count. The count is then replayed as extra reference down-ramp time before the result counter starts. What remains of the down-ramp, up to the comparator trip, is the reading: a 3.5-digit magnitude from 0 to 1999 with a sign flag, an over-range flag and a one-cycle end-of-conversion strobe. With the default parameters one cycle takes about 16,000 clocks. The integrator, comparator and switches are outside the block.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is high and in the cycle after it is released, the block is in the first auto-zero phase: `az_short_o` and `ofs_chg_o` are 1, all other switch outputs are 0, and `reading_o`, `neg_o`, `over_o` and `eoc_o` are 0. The stored polarity is positive.
- R2: Each of the two auto-zero phases (phase 1 and phase 3) holds `az_short_o` and `ofs_chg_o` high for exactly AZ_CYC clocks (4000 by default). `cmp_i` has no effect on their length.
- R3: In the offset phase (`ofs_meas_o` = 1), the first clock that samples `cmp_i` = 1 ends the phase. The number of clocks before that clock, counted from 0, is stored as the offset count, so the phase lasts offset + 1 clocks.
- R4: If `cmp_i` is still 0 after OFS_LIMIT clocks (800 by default) in the offset phase, the phase ends anyway and the stored offset saturates at OFS_LIMIT-1 (799).
- R5: The up-ramp phase (`in_sel_o` = 1) lasts exactly RAMP_LEN = (FULL_SCALE+1) << RES_SHIFT clocks (4000 by default). Throughout it, `in_inv_o` equals the polarity that was decided in the previous cycle (1 means negative).
- R6: `ref_sel_o` stays high without a break through phases 5 and 6. Phase 5 lasts exactly the stored offset count and is skipped when that count is 0.
- R7: In phase 6, the first clock that samples `cmp_i` = 1 ends the conversion. With c the number of phase-6 clocks before that clock, the reading is min(c >> RES_SHIFT, FULL_SCALE). A trip on the last phase-6 clock gives full scale, 1999.
- R8: If `cmp_i` does not go to 1 within RAMP_LEN phase-6 clocks, `over_o` becomes 1 and `reading_o` becomes FULL_SCALE (1999).
- R9: On the last up-ramp clock the polarity becomes old XOR NOT `cmp_i`. `ref_inv_o` shows the new polarity throughout phases 5 and 6, and `neg_o` reports it at the next strobe.
- R10: `eoc_o` is high for exactly one clock, the one after the conversion ends. On the same edge `reading_o`, `neg_o` and `over_o` take their new values, which then hold until the next strobe, and the block returns to phase 1.
- R11: At most one of `az_short_o`, `ofs_meas_o`, `in_sel_o` and `ref_sel_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparator output, 1 = tripped |
| az_short_o | output | 1 | Integrator short switch |
| ofs_chg_o | output | 1 | Offset capacitor charge switch |
| ofs_meas_o | output | 1 | Offset-measurement ramp configuration |
| in_sel_o | output | 1 | Connect the unknown input to the integrator |
| in_inv_o | output | 1 | Inverted input configuration during the up-ramp |
| ref_sel_o | output | 1 | Connect the reference to the integrator |
| ref_inv_o | output | 1 | Reference direction for a negative input |
| reading_o | output | RD_W (11) | Magnitude reading, 0 to FULL_SCALE |
| neg_o | output | 1 | Sign of the last reading, 1 = negative |
| over_o | output | 1 | Over-range flag of the last reading |
| eoc_o | output | 1 | One-clock end-of-conversion strobe |

## Verification
The bench models the comparator with a chosen offset and input magnitude. It targets the offset count that saturates at the limit: a design without saturation would lengthen the offset phase and misplace the result. A zero offset tests whether phase 5 is skipped; a design that runs one clock of it anyway, or wraps the count, shifts every reading. Two boundary cases sit side by side: a trip on the last phase-6 clock must read 1999 without the over-range flag, and a trip one clock later must set it. Zero inputs must keep the previous sign, and comparator noise during auto-zero must not shorten those phases; an off-by-one in any phase length appears as a wrong measured duration or as readings that are off by one count.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  // Conversion phases, executed strictly in this order.
  typedef enum logic [2:0] {
    SEG_AZ1 = 3'd0,  // integrator shorted, offset capacitor charging
    SEG_OFS = 3'd1,  // comparator offset measured in clocks
    SEG_AZ2 = 3'd2,  // second auto-zero
    SEG_INT = 3'd3,  // fixed-length up-ramp on the unknown input
    SEG_DE5 = 3'd4,  // reference down-ramp replaying the offset
    SEG_DE6 = 3'd5   // reference down-ramp that yields the reading
  } seg_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ds_offset_reg.sv
module ds_offset_reg #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [OFS_W-1:0] cap_val,
  output logic [OFS_W-1:0] ofs_q
);

  always_ff @(posedge clk) begin
    if (rst)
      ofs_q <= '0;
    else if (cap_en)
      ofs_q <= cap_val;
  end

endmodule

// File: rtl/ds_seg_fsm.sv
module ds_seg_fsm
  import dsadc_pkg::*;
#(
  parameter int AZ_CYC    = 4000,
  parameter int OFS_LIMIT = 800,
  parameter int RAMP_LEN  = 4000,
  parameter int CNT_W     = 12,
  parameter int OFS_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_i,
  input  logic [OFS_W-1:0] ofs_q,
  output seg_e             seg_nxt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pol_q,
  output logic             pol_nxt,
  output logic             cap_en,
  output logic [OFS_W-1:0] cap_val,
  output logic             done,
  output logic             done_over
);

  localparam logic [CNT_W-1:0] AZ_END   = CNT_W'(AZ_CYC - 1);
  localparam logic [CNT_W-1:0] OFS_END  = CNT_W'(OFS_LIMIT - 1);
  localparam logic [CNT_W-1:0] RAMP_END = CNT_W'(RAMP_LEN - 1);

  seg_e             seg_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] ofs_ext;
  logic             seg_end;

  assign ofs_ext = CNT_W'(ofs_q);

  always_comb begin
    seg_nxt   = seg_q;
    seg_end   = 1'b0;
    pol_nxt   = pol_q;
    cap_en    = 1'b0;
    done      = 1'b0;
    done_over = 1'b0;
    // The counter never passes OFS_LIMIT-1 in the offset phase, so the
    // capture value is already saturated when the limit ends the phase.
    cap_val   = cnt_q[OFS_W-1:0];
    case (seg_q)
      SEG_AZ1: begin
        if (cnt_q == AZ_END) begin
          seg_nxt = SEG_OFS;
          seg_end = 1'b1;
        end
      end
      SEG_OFS: begin
        if (cmp_i || (cnt_q == OFS_END)) begin
          cap_en  = 1'b1;
          seg_nxt = SEG_AZ2;
          seg_end = 1'b1;
        end
      end
      SEG_AZ2: begin
        if (cnt_q == AZ_END) begin
          seg_nxt = SEG_INT;
          seg_end = 1'b1;
        end
      end
      SEG_INT: begin
        if (cnt_q == RAMP_END) begin
          // comparator low after the up-ramp means the configuration was wrong
          pol_nxt = pol_q ^ ~cmp_i;
          seg_nxt = (ofs_q == '0) ? SEG_DE6 : SEG_DE5;
          seg_end = 1'b1;
        end
      end
      SEG_DE5: begin
        if (cnt_q == (ofs_ext - CNT_W'(1))) begin
          seg_nxt = SEG_DE6;
          seg_end = 1'b1;
        end
      end
      SEG_DE6: begin
        if (cmp_i) begin
          done    = 1'b1;
          seg_nxt = SEG_AZ1;
          seg_end = 1'b1;
        end else if (cnt_q == RAMP_END) begin
          done      = 1'b1;
          done_over = 1'b1;
          seg_nxt   = SEG_AZ1;
          seg_end   = 1'b1;
        end
      end
      default: begin
        seg_nxt = SEG_AZ1;
        seg_end = 1'b1;
      end
    endcase
    cnt_nxt = seg_end ? '0 : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= SEG_AZ1;
      cnt_q <= '0;
      pol_q <= 1'b0;
    end else begin
      seg_q <= seg_nxt;
      cnt_q <= cnt_nxt;
      pol_q <= pol_nxt;
    end
  end

endmodule

// File: rtl/ds_switch_drv.sv
module ds_switch_drv
  import dsadc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  seg_e seg_nxt,
  input  logic pol_nxt,
  output logic az_short_o,
  output logic ofs_chg_o,
  output logic ofs_meas_o,
  output logic in_sel_o,
  output logic in_inv_o,
  output logic ref_sel_o,
  output logic ref_inv_o
);

  logic az_n, ofs_n, int_n, ref_n;

  always_comb begin
    az_n  = (seg_nxt == SEG_AZ1) || (seg_nxt == SEG_AZ2);
    ofs_n = (seg_nxt == SEG_OFS);
    int_n = (seg_nxt == SEG_INT);
    ref_n = (seg_nxt == SEG_DE5) || (seg_nxt == SEG_DE6);
  end

  // Decoded from the next phase so every switch changes on the phase edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      az_short_o <= 1'b1;
      ofs_chg_o  <= 1'b1;
      ofs_meas_o <= 1'b0;
      in_sel_o   <= 1'b0;
      in_inv_o   <= 1'b0;
      ref_sel_o  <= 1'b0;
      ref_inv_o  <= 1'b0;
    end else begin
      az_short_o <= az_n;
      ofs_chg_o  <= az_n;
      ofs_meas_o <= ofs_n;
      in_sel_o   <= int_n;
      in_inv_o   <= int_n & pol_nxt;
      ref_sel_o  <= ref_n;
      ref_inv_o  <= ref_n & pol_nxt;
    end
  end

endmodule

// File: rtl/ds_result_latch.sv
module ds_result_latch #(
  parameter int CNT_W      = 12,
  parameter int RD_W       = 11,
  parameter int FULL_SCALE = 1999,
  parameter int RES_SHIFT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             done_over,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             pol_q,
  output logic [RD_W-1:0]  reading_o,
  output logic             neg_o,
  output logic             over_o,
  output logic             eoc_o
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL_SCALE);

  logic [CNT_W-1:0] scaled;
  logic [RD_W-1:0]  rd_val;

  always_comb begin
    scaled = cnt_q >> RES_SHIFT;
    if (done_over || (scaled > FULL_C))
      rd_val = RD_W'(FULL_SCALE);
    else
      rd_val = scaled[RD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reading_o <= '0;
      neg_o     <= 1'b0;
      over_o    <= 1'b0;
      eoc_o     <= 1'b0;
    end else begin
      eoc_o <= done;
      if (done) begin
        reading_o <= rd_val;
        neg_o     <= pol_q;
        over_o    <= done_over;
      end
    end
  end

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsadc_pkg::*;
#(
  parameter int AZ_CYC     = 4000,
  parameter int OFS_LIMIT  = 800,
  parameter int FULL_SCALE = 1999,
  parameter int RES_SHIFT  = 1,
  localparam int RAMP_LEN  = (FULL_SCALE + 1) << RES_SHIFT,
  localparam int CNT_W     = $clog2(max3(AZ_CYC, OFS_LIMIT, RAMP_LEN) + 1),
  localparam int OFS_W     = $clog2(OFS_LIMIT),
  localparam int RD_W      = $clog2(FULL_SCALE + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmp_i,
  output logic            az_short_o,
  output logic            ofs_chg_o,
  output logic            ofs_meas_o,
  output logic            in_sel_o,
  output logic            in_inv_o,
  output logic            ref_sel_o,
  output logic            ref_inv_o,
  output logic [RD_W-1:0] reading_o,
  output logic            neg_o,
  output logic            over_o,
  output logic            eoc_o
);

  seg_e             seg_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             pol_q, pol_nxt;
  logic             cap_en;
  logic [OFS_W-1:0] cap_val;
  logic [OFS_W-1:0] ofs_q;
  logic             done, done_over;

  ds_seg_fsm #(
    .AZ_CYC   (AZ_CYC),
    .OFS_LIMIT(OFS_LIMIT),
    .RAMP_LEN (RAMP_LEN),
    .CNT_W    (CNT_W),
    .OFS_W    (OFS_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .cmp_i    (cmp_i),
    .ofs_q    (ofs_q),
    .seg_nxt  (seg_nxt),
    .cnt_q    (cnt_q),
    .pol_q    (pol_q),
    .pol_nxt  (pol_nxt),
    .cap_en   (cap_en),
    .cap_val  (cap_val),
    .done     (done),
    .done_over(done_over)
  );

  ds_offset_reg #(
    .OFS_W(OFS_W)
  ) u_ofs (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .cap_val(cap_val),
    .ofs_q  (ofs_q)
  );

  ds_switch_drv u_sw (
    .clk       (clk),
    .rst       (rst),
    .seg_nxt   (seg_nxt),
    .pol_nxt   (pol_nxt),
    .az_short_o(az_short_o),
    .ofs_chg_o (ofs_chg_o),
    .ofs_meas_o(ofs_meas_o),
    .in_sel_o  (in_sel_o),
    .in_inv_o  (in_inv_o),
    .ref_sel_o (ref_sel_o),
    .ref_inv_o (ref_inv_o)
  );

  ds_result_latch #(
    .CNT_W     (CNT_W),
    .RD_W      (RD_W),
    .FULL_SCALE(FULL_SCALE),
    .RES_SHIFT (RES_SHIFT)
  ) u_res (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .done_over(done_over),
    .cnt_q    (cnt_q),
    .pol_q    (pol_q),
    .reading_o(reading_o),
    .neg_o    (neg_o),
    .over_o   (over_o),
    .eoc_o    (eoc_o)
  );

endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int FULL_SCALE = 1999,
  parameter int OFS_LIMIT  = 800,
  parameter int RD_W       = 11,
  parameter int OFS_W      = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            az_short,
  input logic            ofs_meas,
  input logic            in_sel,
  input logic            ref_sel,
  input logic            eoc,
  input logic            over,
  input logic            neg,
  input logic [RD_W-1:0] reading,
  input logic [OFS_W-1:0] ofs_cnt
);

  assert_switch_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({az_short, ofs_meas, in_sel, ref_sel}));

  // After an auto-zero phase comes either the offset phase or the up-ramp.
  assert_az_next_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(az_short) |-> (ofs_meas || in_sel));

  assert_ofs_sat_R4: assert property (@(posedge clk) disable iff (rst)
    ofs_cnt <= OFS_W'(OFS_LIMIT - 1));

  assert_over_full_R8: assert property (@(posedge clk) disable iff (rst)
    over |-> (reading == RD_W'(FULL_SCALE)));

  assert_range_R7: assert property (@(posedge clk) disable iff (rst)
    reading <= RD_W'(FULL_SCALE));

  assert_eoc_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !eoc |-> ($stable(reading) && $stable(over) && $stable(neg)));

  assert_eoc_after_ref_R6: assert property (@(posedge clk) disable iff (rst)
    eoc |-> ($past(ref_sel) && az_short));

endmodule

bind dual_slope_seq dual_slope_seq_chk #(
  .FULL_SCALE(FULL_SCALE),
  .OFS_LIMIT (OFS_LIMIT),
  .RD_W      (RD_W),
  .OFS_W     (OFS_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .az_short(az_short_o),
  .ofs_meas(ofs_meas_o),
  .in_sel  (in_sel_o),
  .ref_sel (ref_sel_o),
  .eoc     (eoc_o),
  .over    (over_o),
  .neg     (neg_o),
  .reading (reading_o),
  .ofs_cnt (ofs_q)
);

// File: tb/sim_dual_slope_seq.sv
module sim_dual_slope_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AZ   = 50;
  localparam int OL   = 800;
  localparam int FS   = 1999;
  localparam int SH   = 0;
  localparam int RAMP = (FS + 1) << SH;
  localparam int RDW  = 11;
  localparam int NCONV = 20;
  localparam int WD_LIMIT = 180000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp = 1'b0;
  logic az_short, ofs_chg, ofs_meas, in_sel, in_inv, ref_sel, ref_inv;
  logic [RDW-1:0] reading;
  logic neg, over, eoc;

  dual_slope_seq #(
    .AZ_CYC(AZ), .OFS_LIMIT(OL), .FULL_SCALE(FS), .RES_SHIFT(SH)
  ) u0 (
    .clk(clk), .rst(rst), .cmp_i(cmp),
    .az_short_o(az_short), .ofs_chg_o(ofs_chg), .ofs_meas_o(ofs_meas),
    .in_sel_o(in_sel), .in_inv_o(in_inv), .ref_sel_o(ref_sel),
    .ref_inv_o(ref_inv), .reading_o(reading), .neg_o(neg),
    .over_o(over), .eoc_o(eoc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cycles = 0;
  bit wd_hit = 1'b0, all_done = 1'b0, running = 1'b0;

  // model of the current conversion
  int K, N, stored, c_exp, exp_rd;
  bit vneg, exp_over, exp_neg, cfg_neg;
  int conv = 0;
  int run_az = 0, run_ofs = 0, run_int = 0, run_ref = 0, excl_viol = 0;
  int last_rd = 0;
  bit last_neg = 0, last_over = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int i);
    case (i)
      0: begin K = 10;  N = 500;  vneg = 1'b0; end
      1: begin K = 0;   N = 0;    vneg = 1'b1; end  // zero offset, zero input
      2: begin K = 900; N = 300;  vneg = 1'b1; end  // offset saturates
      3: begin K = 5;   N = 1999; vneg = 1'b0; end  // last-clock trip
      4: begin K = 5;   N = 2000; vneg = 1'b0; end  // one clock late: over
      5: begin K = 20;  N = 2500; vneg = 1'b1; end
      6: begin K = 799; N = 0;    vneg = 1'b0; end  // zero keeps negative
      7: begin K = 800; N = 10;   vneg = 1'b0; end
      default: begin
        K = int'($urandom % 700);
        N = int'($urandom % 2050);
        vneg = 1'($urandom % 2);
      end
    endcase
    stored   = (K < OL) ? K : OL - 1;
    c_exp    = K + N - stored;
    exp_over = (c_exp >= RAMP);
    exp_rd   = exp_over ? FS : (((c_exp >> SH) > FS) ? FS : (c_exp >> SH));
    exp_neg  = (N == 0) ? cfg_neg : vneg;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) wd_hit = 1'b1;
  end

  always @(negedge clk) begin
    bit cv;
    if (running && !all_done) begin
      cv = 1'($urandom % 2);   // noise outside measured phases (R2)
      if ($countones({az_short, ofs_meas, in_sel, ref_sel}) > 1) excl_viol++;

      if (az_short) begin
        if (ofs_chg !== 1'b1) check("R2", "offset charge with short", ofs_chg, 1);
        run_az++;
      end else if (run_az > 0) begin
        check("R2", "auto-zero length", run_az, AZ);
        run_az = 0;
      end

      if (ofs_meas) begin
        cv = (run_ofs >= K);
        run_ofs++;
      end else if (run_ofs > 0) begin
        if (K < OL) check("R3", "offset phase length", run_ofs, K + 1);
        else        check("R4", "saturated offset phase length", run_ofs, OL);
        run_ofs = 0;
      end

      if (in_sel) begin
        if (run_int == 0) begin
          check("R10", "reading held", int'(reading), last_rd);
          check("R10", "sign held", int'(neg), int'(last_neg));
          check("R10", "over held", int'(over), int'(last_over));
          check("R5", "input inversion", int'(in_inv), int'(cfg_neg));
        end
        cv = (N == 0) || (vneg == in_inv);
        run_int++;
      end else if (run_int > 0) begin
        check("R5", "up-ramp length", run_int, RAMP);
        run_int = 0;
      end

      if (ref_sel) begin
        if (run_ref == 0) check("R9", "reference direction", int'(ref_inv), int'(exp_neg));
        cv = (run_ref >= K + N);
        run_ref++;
      end else if (run_ref > 0) begin
        check("R6", "reference phase length", run_ref,
              exp_over ? stored + RAMP : K + N + 1);
        run_ref = 0;
      end

      if (eoc) begin
        check(exp_over ? "R8" : "R7", "reading", int'(reading), exp_rd);
        check("R8", "over-range flag", int'(over), int'(exp_over));
        check("R9", "sign", int'(neg), int'(exp_neg));
        check("R11", "switch exclusivity violations", excl_viol, 0);
        last_rd = int'(reading); last_neg = neg; last_over = over;
        cfg_neg = exp_neg;
        conv++;
        if (conv == NCONV) all_done = 1'b1;
        else load(conv);
      end
      cmp = cv;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cfg_neg = 1'b0;
    load(0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "short in reset", int'(az_short), 1);
    check("R1", "charge in reset", int'(ofs_chg), 1);
    check("R1", "other switches in reset",
          int'({ofs_meas, in_sel, in_inv, ref_sel, ref_inv}), 0);
    check("R1", "outputs in reset", int'({reading, neg, over, eoc}), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    running = 1'b1;
    wait (all_done || wd_hit);
    if (!all_done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d conversions expected %0d", conv, NCONV);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule